// File: doc/BRIEF.md
# Three-Level Space Vector Triangle Locator

This block takes a reference voltage vector, given as an unsigned magnitude and an unsigned angle, and places it inside the hexagon of a three-level inverter. The hexagon is divided into six 60-degree sectors, and each sector is split into four triangles. The block reports the sector, the triangle number (1 to 24), the family of that triangle (1 to 4) and the angle measured from the start of the sector. A later duty-time stage uses these results to pick the three nearest vectors and to choose the closed-form expressions for their on-times.

A new vector is taken on each cycle where the modulation period strobe is high. Sector search and triangle classification are combinational. They are registered once, so the results appear one cycle later together with a single-cycle valid pulse. The results then hold until the next strobe. Inside a sector, the vector is projected onto the two sector edges using constant sine tables. The two projections are compared against half the hexagon vertex radius to decide between the inner triangle and the three outer triangles.

Top module: `tri_locator`

## Requirements
- R1: During and right after reset, sector_o, triangle_o, family_o and local_ang_o are all 0 and valid_o is low.
- R2: When strobe_i is high at a rising clock edge, ang_i and mag_i are sampled on that edge. The results for them appear on the outputs after that edge, and valid_o is high for exactly the one following cycle.
- R3: When strobe_i is low, every result output keeps its value and valid_o stays low, whatever ang_i and mag_i do.
- R4: ang_i is unsigned, and 2^ANG_W counts make 360 degrees. sector_o is the largest k in 1..6 with ang_i >= ceil((k-1)*2^ANG_W/6).
- R5: local_ang_o equals ang_i minus ceil((k-1)*2^ANG_W/6), where k is the reported sector.
- R6: mag_i is unsigned, and 2^MAG_W stands for the radius of a hexagon vertex. Two projections are formed, with theta the local angle in degrees: p1 = mag·(2/√3)·sin(60°−theta) toward the sector start edge, and p2 = mag·(2/√3)·sin(theta) toward the end edge. At local angle 0, p1 equals mag exactly.
- R7: family_o is 1 (inner triangle) when p1+p2 <= 2^(MAG_W−1). A sum exactly equal to that half value counts as inner.
- R8: When the vector is not inner, family_o is 2 if p1 >= 2^(MAG_W−1). Otherwise it is 4 if p2 >= 2^(MAG_W−1), and otherwise 3. The p1 test wins when both projections exceed the half value, which happens beyond the hexagon.
- R9: triangle_o = 4·(sector_o−1) + family_o, so family_o = ((triangle_o−1) mod 4)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Modulation period strobe; samples the vector |
| ang_i | input | ANG_W | Reference angle, full scale = 360 degrees |
| mag_i | input | MAG_W | Reference magnitude, full scale = hexagon vertex radius |
| valid_o | output | 1 | One-cycle pulse marking fresh results |
| sector_o | output | 3 | Sector number 1..6 |
| triangle_o | output | 5 | Triangle number 1..24 |
| family_o | output | 3 | Triangle family 1..4 |
| local_ang_o | output | ANG_W | Angle from the start of the sector |

## Verification
The main sweep places one vector in each of the 24 triangles. Each sector is visited near its start edge, at its centre and near its end edge, at both a small and a large magnitude. This separates errors in the sector search from errors in the inner/outer split and from errors in choosing among the three outer families. Directed vectors then test angles one count on either side of a sector boundary and the last count before wrap-around. They also put a magnitude exactly on the inner threshold and one count above it at a local angle of zero, where the projection is exact. A vector beyond the hexagon tests the priority of the start-edge comparison. A final stretch with the strobe low and the inputs changing shows that the registered results hold.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [2:0] {
        FAM_NONE  = 3'd0,
        FAM_INNER = 3'd1,
        FAM_START = 3'd2,
        FAM_MID   = 3'd3,
        FAM_END   = 3'd4
    } fam_e;

    // Sector start boundary j (0..6): ceil(j * 2^ang_w / 6)
    function automatic longint sec_bound(input int j, input int ang_w);
        longint full;
        full = longint'(1) << ang_w;
        return (longint'(j) * full + 5) / 6;
    endfunction

    // Scaled edge projection coefficient for a local angle count.
    // toward_start = 1 gives (2/sqrt3)*sin(60deg - a), else (2/sqrt3)*sin(a).
    function automatic int proj_coef(input int cnt, input int ang_w,
                                     input int frac, input bit toward_start);
        real deg;
        real x;
        real term;
        real s;
        real scale;
        deg = real'(cnt) * 360.0 / real'(longint'(1) << ang_w);
        if (toward_start) deg = 60.0 - deg;
        if (deg < 0.0) deg = 0.0;
        x    = deg * 3.14159265358979323846 / 180.0;
        s    = x;
        term = x;
        for (int i = 1; i < 10; i++) begin
            term = -term * x * x / real'((2 * i) * (2 * i + 1));
            s    = s + term;
        end
        scale = real'(longint'(1) << frac);
        return $rtoi(1.1547005383792515 * s * scale + 0.5);
    endfunction

endpackage

// File: rtl/tl_sector_find.sv
module tl_sector_find #(
    parameter int ANG_W = 10
) (
    input  logic [ANG_W-1:0] ang_i,
    output logic [2:0]       sector_o,
    output logic [ANG_W-1:0] local_o
);
    localparam int NB = 5;

    logic [NB-1:0]    above;
    logic [ANG_W-1:0] base [NB+1];

    assign base[0] = '0;

    for (genvar j = 1; j <= NB; j++) begin : g_bound
        localparam logic [ANG_W-1:0] BND = ANG_W'(tl_pkg::sec_bound(j, ANG_W));
        assign base[j]    = BND;
        assign above[j-1] = (ang_i >= BND);
    end

    always_comb begin
        logic [2:0] cnt_d;
        cnt_d = 3'd0;
        for (int i = 0; i < NB; i++) begin
            cnt_d = cnt_d + {2'b00, above[i]};
        end
        sector_o = cnt_d + 3'd1;
        local_o  = ang_i - base[cnt_d];
    end

endmodule

// File: rtl/tl_proj.sv
module tl_proj #(
    parameter int ANG_W     = 10,
    parameter int MAG_W     = 12,
    parameter int COEF_FRAC = 11,
    parameter int DEPTH     = 171,
    parameter int P_W       = 13
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic [ANG_W-1:0] local_i,
    output logic [P_W-1:0]   p_start_o,
    output logic [P_W-1:0]   p_end_o
);
    localparam int COEF_W = COEF_FRAC + 1;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PROD_W = MAG_W + COEF_W;

    logic [COEF_W-1:0] lut_start [DEPTH];
    logic [COEF_W-1:0] lut_end   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        localparam int CS = tl_pkg::proj_coef(g, ANG_W, COEF_FRAC, 1'b1);
        localparam int CE = tl_pkg::proj_coef(g, ANG_W, COEF_FRAC, 1'b0);
        assign lut_start[g] = COEF_W'(CS);
        assign lut_end[g]   = COEF_W'(CE);
    end

    logic [IDX_W-1:0]  idx;
    logic [PROD_W-1:0] prod_s;
    logic [PROD_W-1:0] prod_e;

    always_comb begin
        if (local_i >= ANG_W'(DEPTH)) idx = IDX_W'(DEPTH - 1);
        else                          idx = local_i[IDX_W-1:0];
        prod_s    = PROD_W'(mag_i) * PROD_W'(lut_start[idx]);
        prod_e    = PROD_W'(mag_i) * PROD_W'(lut_end[idx]);
        p_start_o = prod_s[PROD_W-1:COEF_FRAC];
        p_end_o   = prod_e[PROD_W-1:COEF_FRAC];
    end

endmodule

// File: rtl/tl_classify.sv
module tl_classify #(
    parameter int MAG_W = 12,
    parameter int P_W   = 13
) (
    input  logic [P_W-1:0] p_start_i,
    input  logic [P_W-1:0] p_end_i,
    input  logic [2:0]     sector_i,
    output tl_pkg::fam_e   family_o,
    output logic [4:0]     triangle_o
);
    localparam logic [P_W:0]   HALF_W = (P_W+1)'(1) << (MAG_W - 1);
    localparam logic [P_W-1:0] HALF   = P_W'(HALF_W);

    logic [P_W:0] sum;

    always_comb begin
        sum = {1'b0, p_start_i} + {1'b0, p_end_i};
        if (sum <= HALF_W)          family_o = tl_pkg::FAM_INNER;
        else if (p_start_i >= HALF) family_o = tl_pkg::FAM_START;
        else if (p_end_i >= HALF)   family_o = tl_pkg::FAM_END;
        else                        family_o = tl_pkg::FAM_MID;
        triangle_o = {sector_i - 3'd1, 2'b00} + {2'b00, family_o};
    end

endmodule

// File: rtl/tri_locator.sv
module tri_locator #(
    parameter int ANG_W     = 10,
    parameter int MAG_W     = 12,
    parameter int COEF_FRAC = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [ANG_W-1:0] ang_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic             valid_o,
    output logic [2:0]       sector_o,
    output logic [4:0]       triangle_o,
    output logic [2:0]       family_o,
    output logic [ANG_W-1:0] local_ang_o
);
    localparam int DEPTH = int'(tl_pkg::sec_bound(1, ANG_W));
    localparam int P_W   = MAG_W + 1;
    localparam logic [MAG_W:0] HALF = (MAG_W+1)'(1) << (MAG_W - 1);

    typedef struct packed {
        logic             vld;
        logic [2:0]       sector;
        logic [4:0]       trg;
        logic [2:0]       fam;
        logic [ANG_W-1:0] loc;
    } st_t;

    st_t st_d, st_q;

    logic [2:0]       sec_w;
    logic [ANG_W-1:0] loc_w;
    logic [P_W-1:0]   ps_w, pe_w;
    tl_pkg::fam_e     fam_w;
    logic [4:0]       trg_w;

    tl_sector_find #(.ANG_W(ANG_W)) u_sec (
        .ang_i    (ang_i),
        .sector_o (sec_w),
        .local_o  (loc_w)
    );

    tl_proj #(
        .ANG_W(ANG_W), .MAG_W(MAG_W), .COEF_FRAC(COEF_FRAC),
        .DEPTH(DEPTH), .P_W(P_W)
    ) u_proj (
        .mag_i     (mag_i),
        .local_i   (loc_w),
        .p_start_o (ps_w),
        .p_end_o   (pe_w)
    );

    tl_classify #(.MAG_W(MAG_W), .P_W(P_W)) u_cls (
        .p_start_i  (ps_w),
        .p_end_i    (pe_w),
        .sector_i   (sec_w),
        .family_o   (fam_w),
        .triangle_o (trg_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (strobe_i) begin
            st_d.vld    = 1'b1;
            st_d.sector = sec_w;
            st_d.trg    = trg_w;
            st_d.fam    = fam_w;
            st_d.loc    = loc_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o     = st_q.vld;
    assign sector_o    = st_q.sector;
    assign triangle_o  = st_q.trg;
    assign family_o    = st_q.fam;
    assign local_ang_o = st_q.loc;

    // Results hold while no strobe arrives
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(sector_o) && $stable(triangle_o)
                       && $stable(family_o) && $stable(local_ang_o) && !valid_o));

    // Reported ranges of sector and family
    assert_sector_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sector_o >= 3'd1 && sector_o <= 3'd6));
    assert_family_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (family_o >= 3'd1 && family_o <= 3'd4));

    // In the first sector the local angle is the sampled angle itself
    assert_first_sector_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (sector_o != 3'd1 || local_ang_o == $past(ang_i)));

    // Local angle always indexes inside the projection tables
    assert_local_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (local_ang_o < ANG_W'(DEPTH)));

    // An inner triangle is never reported for a magnitude above the half radius
    assert_inner_mag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (family_o != 3'd1 || {1'b0, $past(mag_i)} <= HALF));

endmodule

// File: tb/tri_locator_tb.sv
module tri_locator_tb_top;
    localparam int ANG_W = 10;
    localparam int MAG_W = 12;
    localparam int NV    = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic [ANG_W-1:0] ang = '0;
    logic [MAG_W-1:0] mag = '0;
    logic             valid;
    logic [2:0]       sector;
    logic [4:0]       triangle;
    logic [2:0]       family;
    logic [ANG_W-1:0] loc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tri_locator #(.ANG_W(ANG_W), .MAG_W(MAG_W), .COEF_FRAC(11)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .ang_i(ang), .mag_i(mag),
        .valid_o(valid), .sector_o(sector), .triangle_o(triangle),
        .family_o(family), .local_ang_o(loc)
    );

    // {angle, magnitude, expected triangle}
    localparam int VEC [NV][3] = '{
        '{85,  3000, 3},  '{20,  3000, 2},  '{150, 3000, 4},  '{85,  1500, 1},
        '{191, 3000, 6},  '{256, 1500, 5},  '{492, 3000, 12}, '{427, 3000, 11},
        '{532, 3000, 14}, '{662, 3000, 16}, '{768, 3000, 19}, '{703, 1500, 17},
        '{1004,3000, 24}, '{874, 3000, 22}, '{939, 3000, 23}, '{321, 3000, 8},
        '{362, 3000, 10}, '{597, 1500, 13}, '{833, 3000, 20}, '{939, 1000, 21},
        '{256, 3000, 7},  '{597, 3000, 15}, '{703, 3000, 18}, '{427, 1500, 9}
    };

    function automatic int bnd(input int j);
        return (j * (1 << ANG_W) + 5) / 6;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe one vector, then sample between edges once results are registered
    task automatic apply(input int a, input int m);
        @(negedge clk);
        ang    = ANG_W'(a);
        mag    = MAG_W'(m);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic expect_tri(input int a, input int t, input string tag);
        int k;
        k = (t - 1) / 4 + 1;
        chk({tag, " R2 valid"}, int'(valid), 1);
        chk({tag, " R4 sector"}, int'(sector), k);
        chk({tag, " R5 local"}, int'(loc), a - bnd(k - 1));
        chk({tag, " R7/R8 family"}, int'(family), (t - 1) % 4 + 1);
        chk({tag, " R9 triangle"}, int'(triangle), t);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(valid), 0);
        chk("R1 sector", int'(sector), 0);
        chk("R1 triangle", int'(triangle), 0);
        chk("R1 family", int'(family), 0);
        chk("R1 local", int'(loc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(triangle), 0);

        // Main sweep across all 24 triangles (R6, R7, R8, R9)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][0], VEC[i][1]);
            expect_tri(VEC[i][0], VEC[i][2], "sweep");
            @(negedge clk);
            chk("R2 valid single cycle", int'(valid), 0);
        end

        // R4/R5: sector boundaries and wrap
        apply(170, 0);  expect_tri(170, 1, "edge170");
        apply(171, 0);  expect_tri(171, 5, "edge171");
        apply(1023, 0); expect_tri(1023, 21, "edge1023");
        apply(511, 0);  expect_tri(511, 9, "edge511");
        apply(512, 0);  expect_tri(512, 13, "edge512");

        // R7: exact threshold at local angle 0
        apply(0, 2048);   expect_tri(0, 1, "R7 tie");
        apply(0, 2049);   expect_tri(0, 2, "R7 above");
        apply(512, 2048); expect_tri(512, 13, "R7 tie s4");
        apply(512, 2049); expect_tri(512, 14, "R7 above s4");

        // R8: beyond the hexagon, start-edge test has priority
        apply(85, 4095);  expect_tri(85, 2, "R8 priority");

        // R3: hold with strobe low while inputs move
        apply(939, 3000);
        for (int c = 0; c < 5; c++) begin
            ang = ANG_W'(100 + c * 150);
            mag = MAG_W'(500 + c * 700);
            @(negedge clk);
            chk("R3 valid low", int'(valid), 0);
            chk("R3 triangle held", int'(triangle), 23);
            chk("R3 sector held", int'(sector), 6);
            chk("R3 local held", int'(loc), 939 - bnd(5));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule